// File: doc/BRIEF.md
# Integrating Input Level Detector

This block measures the average size of a stream of signed input samples as part of a gain control loop. Each accepted sample is turned into its magnitude. A programmable threshold is subtracted from that magnitude, and the signed difference is added into a wide accumulator. A down-counter sets the integration window as a number of accepted samples.

When the counter reaches zero, the upper part of the accumulator is copied into a holding register. A status flag is raised at the same time, and the accumulator starts the next window from zero. A processor reads the captured level one byte at a time. Reading the top byte acknowledges the result and drops the flag.

The counter can reload itself and run without end, or it can stop after one window. With the threshold at zero, the captured value is the mean magnitude of the input scaled by the window length. With a nonzero threshold, the captured value is the signed error against that threshold.

Top module: `lvl_detect`

## Requirements
- R1: After reset the status flag is 0, all three level bytes read 0, and no capture happens until a nonzero period is written.
- R2: Each accepted sample (smp_valid high while a window runs) adds |sample| - threshold into a 32-bit signed accumulator. At capture, accumulator bits 31:9 are kept and read as a 24-bit sign-extended value: rd_addr 0 gives bits 7:0, 1 gives bits 15:8, 2 gives bits 23:16.
- R3: Samples are 14-bit two's complement. Code -8192 is rectified to 8191.
- R4: Writing a nonzero value P to wr_addr 2 starts a window. Capture happens on the P-th accepted sample, and cycles with smp_valid low neither count nor add.
- R5: When wr_addr 1 bit 0 is 1 (continuous mode), the counter reloads P after each capture. A capture follows every P accepted samples, and each window sums only its own samples.
- R6: When wr_addr 1 bit 0 is 0 (one-shot mode), the counter halts after its capture. Later samples cause no capture until the next start write.
- R7: A start write at any moment clears the accumulator and reloads the counter without capturing. A sample in the same cycle as the write is discarded, and the holding register keeps its value.
- R8: A capture sets the status flag, read as bit 0 at rd_addr 3. A read strobe at rd_addr 2 clears the flag, while reads at rd_addr 0 and 1 leave it set.
- R9: A capture before the previous result was read overwrites the holding register, and the flag stays set.
- R10: Writing period 0 to wr_addr 2 stops the counter, so no captures occur.
- R11: The threshold is 13 bits at wr_addr 0. A threshold above the input magnitude yields a negative captured level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Signed input sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 threshold, 1 mode, 2 period/start |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (acknowledges at address 2) |
| rd_addr | input | 2 | Read select: 0..2 level bytes, 3 status |
| rd_data | output | 8 | Combinational read data |

## Verification
A counter off by one shows at the ports as a capture one sample early or late. The flag rises at the wrong sample, and the read level differs by one sample's contribution. A stale accumulator, or one that was not cleared, adds the previous window into the next reading, so it shows at the second capture of a continuous run. A wrong status update appears at the next read of address 3, one cycle after the capture or the top-byte read. Rectification errors show in the first window that contains the affected code.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  typedef enum logic [1:0] {
    WR_THRESH = 2'd0,
    WR_MODE   = 2'd1,
    WR_START  = 2'd2,
    WR_NONE   = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    RD_LVL_LO  = 2'd0,
    RD_LVL_MID = 2'd1,
    RD_LVL_HI  = 2'd2,
    RD_STATUS  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/lvl_rectify.sv
module lvl_rectify #(
  parameter int SMP_W = 14
) (
  input  logic [SMP_W-1:0]   smp,
  input  logic [SMP_W-2:0]   thr,
  output logic signed [SMP_W:0] diff
);
  localparam int MAG_W = SMP_W - 1;

  // magnitude with the most negative code clamped to the positive maximum (R3)
  function automatic logic [MAG_W-1:0] mag_of(input logic [SMP_W-1:0] s);
    logic [SMP_W-1:0] neg;
    neg = ~s + 1'b1;
    if (!s[SMP_W-1])                return s[MAG_W-1:0];
    else if (s[MAG_W-1:0] == '0)    return '1;
    else                            return neg[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] mag;
  assign mag  = mag_of(smp);
  assign diff = $signed({2'b00, mag}) - $signed({2'b00, thr});
endmodule

// File: rtl/lvl_period_ctr.sv
module lvl_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             cont,
  output logic             running,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, period_q;

  // a load in the same cycle suppresses the terminal count (R7)
  assign done = running && step && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      period_q <= '0;
      running  <= 1'b0;
    end else if (load) begin
      cnt_q    <= load_val;
      period_q <= load_val;
      running  <= (load_val != '0);
    end else if (running && step) begin
      if (cnt_q == CNT_W'(1)) begin
        if (cont) begin
          cnt_q <= period_q;
        end else begin
          cnt_q   <= '0;
          running <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lvl_accum.sv
module lvl_accum #(
  parameter int SMP_W  = 14,
  parameter int ACC_W  = 32,
  parameter int HOLD_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   add,
  input  logic                   dump,
  input  logic signed [SMP_W:0]  diff,
  output logic [ACC_W-1:0]       acc,
  output logic [HOLD_W-1:0]      hold
);
  localparam int EXT_W = ACC_W - SMP_W - 1;

  logic [ACC_W-1:0] acc_next;
  assign acc_next = acc + {{EXT_W{diff[SMP_W]}}, diff};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      hold <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (add) begin
      if (dump) begin
        hold <= acc_next[ACC_W-1 -: HOLD_W];
        acc  <= '0;
      end else begin
        acc <= acc_next;
      end
    end
  end
endmodule

// File: rtl/lvl_detect.sv
module lvl_detect
  import lvl_pkg::*;
#(
  parameter int SMP_W  = 14,
  parameter int ACC_W  = 32,
  parameter int HOLD_W = 23,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data
);
  localparam int RD_W = 24;

  logic [SMP_W-2:0]      thr_q;
  logic                  mode_cont;
  logic                  status_q;
  logic                  start_wr, capture, running, msb_rd, add_en;
  logic signed [SMP_W:0] diff;
  logic [ACC_W-1:0]      acc_q;
  logic [HOLD_W-1:0]     hold_q;
  logic [RD_W-1:0]       lvl_word;

  // named events for the checker
  assign start_wr = wr_en && (wr_sel_e'(wr_addr) == WR_START);
  assign msb_rd   = rd_en && (rd_sel_e'(rd_addr) == RD_LVL_HI);
  assign add_en   = smp_valid && running && !start_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q     <= '0;
      mode_cont <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel_e'(wr_addr))
        WR_THRESH: thr_q     <= wr_data[SMP_W-2:0];
        WR_MODE:   mode_cont <= wr_data[0];
        default:   ;
      endcase
    end
  end

  lvl_rectify #(.SMP_W(SMP_W)) u_rect (
    .smp  (smp_data),
    .thr  (thr_q),
    .diff (diff)
  );

  lvl_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_wr),
    .load_val (wr_data),
    .step     (smp_valid),
    .cont     (mode_cont),
    .running  (running),
    .done     (capture)
  );

  lvl_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W), .HOLD_W(HOLD_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_wr),
    .add   (add_en),
    .dump  (capture),
    .diff  (diff),
    .acc   (acc_q),
    .hold  (hold_q)
  );

  // capture outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)       status_q <= 1'b0;
    else if (capture) status_q <= 1'b1;
    else if (msb_rd)  status_q <= 1'b0;
  end

  assign lvl_word = {{(RD_W-HOLD_W){hold_q[HOLD_W-1]}}, hold_q};

  always_comb begin
    case (rd_sel_e'(rd_addr))
      RD_LVL_LO:  rd_data = lvl_word[7:0];
      RD_LVL_MID: rd_data = lvl_word[15:8];
      RD_LVL_HI:  rd_data = lvl_word[23:16];
      default:    rd_data = {7'd0, status_q};
    endcase
  end
endmodule

// File: rtl/lvl_detect_chk.sv
module lvl_detect_chk #(
  parameter int ACC_W  = 32,
  parameter int HOLD_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_wr,
  input logic              capture,
  input logic              running,
  input logic              mode_cont,
  input logic              status_q,
  input logic              msb_rd,
  input logic [ACC_W-1:0]  acc_q,
  input logic [HOLD_W-1:0] hold_q
);
  p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> status_q);

  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msb_rd && !capture) |=> !status_q);

  p_status_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !msb_rd) |=> status_q);

  p_restart_no_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> !capture);

  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (acc_q == '0));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(hold_q));

  p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !mode_cont) |=> !running);

  p_cont_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && mode_cont) |=> (running && acc_q == '0));
endmodule

bind lvl_detect lvl_detect_chk #(.ACC_W(ACC_W), .HOLD_W(HOLD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_wr  (start_wr),
  .capture   (capture),
  .running   (running),
  .mode_cont (mode_cont),
  .status_q  (status_q),
  .msb_rd    (msb_rd),
  .acc_q     (acc_q),
  .hold_q    (hold_q)
);

// File: tb/tb_lvl_detect.sv
module tb_lvl_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_data = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  lvl_detect dut (.*);

  function automatic int contrib(input logic [13:0] x, input int thr);
    int sv, m;
    sv = $signed(x);
    if (sv == -8192) m = 8191;
    else m = (sv < 0) ? -sv : sv;
    return m - thr;
  endfunction

  function automatic logic [23:0] exp_lvl(input int s);
    int q;
    q = s >>> 9;
    return q[23:0];
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input logic [13:0] x);
    smp_valid = 1'b1; smp_data = x;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1 v = rd_data;
  endtask

  task automatic read_byte(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; rd_en = 1'b1; #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_lvl(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    read_byte(2'd0, b0);
    read_byte(2'd1, b1);
    read_byte(2'd2, b2);
    v = {b2, b1, b0};
  endtask

  task automatic status(output logic s);
    logic [7:0] v;
    peek(2'd3, v);
    s = v[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] lv;
    logic        st;
    int          sum, thr, per;
    logic [13:0] x;
    int          seed_dummy;
    seed_dummy = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    status(st); check("R1 status after reset", st, 0);
    peek(2'd0, b); check("R1 byte0 after reset", b, 0);
    peek(2'd2, b); check("R1 byte2 after reset", b, 0);
    for (int i = 0; i < 20; i++) push(14'd4000);
    status(st); check("R1 no capture without start", st, 0);

    // R2 R4: one-shot, gaps between samples
    wr(2'd0, 16'd0); wr(2'd1, 16'd0); wr(2'd2, 16'd8);
    for (int i = 0; i < 7; i++) begin push(14'd8000); idle(2); end
    status(st); check("R4 no capture before last sample", st, 0);
    push(14'd8000);
    status(st); check("R4 capture on P-th sample", st, 1);
    read_lvl(lv); check("R2 level value", lv, exp_lvl(8 * 8000));
    status(st); check("R8 top byte read clears", st, 0);

    // R6: after one-shot, no further capture
    for (int i = 0; i < 20; i++) push(14'd3000);
    status(st); check("R6 halted after one window", st, 0);

    // R3: most negative code
    wr(2'd2, 16'd512);
    for (int i = 0; i < 512; i++) push(14'h2000);
    read_lvl(lv); check("R3 most negative saturates", lv, exp_lvl(512 * 8191));

    // R11: threshold above magnitude gives negative level
    wr(2'd0, 16'd5000); wr(2'd2, 16'd1024);
    for (int i = 0; i < 1024; i++) push(14'd1000);
    read_lvl(lv); check("R11 negative level", lv, exp_lvl(1024 * (1000 - 5000)));

    // R8: low/mid byte reads keep flag
    wr(2'd0, 16'd0); wr(2'd2, 16'd3);
    for (int i = 0; i < 3; i++) push(14'd100);
    read_byte(2'd0, b); read_byte(2'd1, b);
    status(st); check("R8 low bytes keep flag", st, 1);
    read_byte(2'd2, b);
    status(st); check("R8 top byte clears flag", st, 0);

    // R5 R9: continuous random windows
    thr = int'($urandom_range(0, 3000));
    per = int'($urandom_range(5, 40));
    wr(2'd0, 16'(thr)); wr(2'd1, 16'd1); wr(2'd2, 16'(per));
    for (int w = 0; w < 4; w++) begin
      sum = 0;
      for (int i = 0; i < per; i++) begin
        x = 14'($urandom);
        sum += contrib(x, thr);
        push(x);
        if ($urandom_range(0, 3) == 0) idle(1);
      end
      if (w == 2) begin
        status(st); check("R9 flag stays set on overwrite", st, 1);
        read_lvl(lv); check("R9 overwritten value", lv, exp_lvl(sum));
      end else if (w != 1) begin
        read_lvl(lv); check("R5 continuous window value", lv, exp_lvl(sum));
      end
    end

    // R7: restart mid window, and on the completing sample
    wr(2'd0, 16'd0); wr(2'd1, 16'd0); wr(2'd2, 16'd6);
    for (int i = 0; i < 3; i++) push(14'd7000);
    wr(2'd2, 16'd4);
    for (int i = 0; i < 3; i++) push(14'd2048);
    smp_valid = 1'b1; smp_data = 14'd8000;
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd4;
    @(negedge clk);
    smp_valid = 1'b0; wr_en = 1'b0;
    status(st); check("R7 restart does not capture", st, 0);
    for (int i = 0; i < 4; i++) push(14'h3C00);   // -1024
    read_lvl(lv); check("R7 only samples after restart", lv, exp_lvl(4 * 1024));

    // R10: zero period stops counting
    wr(2'd1, 16'd1); wr(2'd2, 16'd2); push(14'd10);
    wr(2'd2, 16'd0);
    for (int i = 0; i < 10; i++) push(14'd10);
    status(st); check("R10 zero period stops", st, 0);

    // R2 R4: random one-shot windows
    wr(2'd1, 16'd0);
    for (int t = 0; t < 6; t++) begin
      thr = int'($urandom_range(0, 8191));
      per = int'($urandom_range(1, 300));
      wr(2'd0, 16'(thr)); wr(2'd2, 16'(per));
      sum = 0;
      for (int i = 0; i < per; i++) begin
        x = 14'($urandom);
        sum += contrib(x, thr);
        push(x);
      end
      read_lvl(lv); check("R2 random one-shot value", lv, exp_lvl(sum));
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule